// File: doc/BRIEF.md
# Tone-Interval FSK Receive Demodulator

This block turns the squared-up output of an analog receive comparator back into a serial bit stream for a UART. The comparator output is a single bit, and it is sampled on a 460.8 kHz clock. The block times the gap between consecutive transitions of that bit. A long gap, about 192 clocks, comes from the 1200 Hz mark tone. A short gap, about 105 clocks, comes from the 2200 Hz space tone. Each timed gap sets the level of the recovered data, so a 1200 bit/s stream shows up on the data output at the tone rate.

The block also tracks whether a carrier is present, using the gaps themselves as evidence. A run of in-band gaps declares a carrier. A run of out-of-band gaps, or a long silence with no transitions, removes it. While no carrier is declared, the data output rests at the idle mark level. The receiving UART therefore sees a quiet line instead of noise.

Top module: `fsk_rx_demod`

## Requirements
- R1: While the synchronous active-low reset is applied, and directly after it, carrier_det is 0 and rx_data is 1.
- R2: With a carrier present, a gap of 192 clocks (1200 Hz) drives rx_data to 1.
- R3: With a carrier present, a gap of 105 clocks (2200 Hz) drives rx_data to 0.
- R4: The tone decision splits at 148 clocks. A gap of 148 clocks gives 1, and a gap of 147 clocks gives 0.
- R5: carrier_det rises on the 8th in-band gap in a row and not on the 7th.
- R6: A gap is in band from 80 to 240 clocks, both ends included. A gap of 79 or 241 clocks is out of band and restarts the in-band run. The first transition after reset or after a silence is always out of band.
- R7: carrier_det falls on the 4th out-of-band gap in a row and not on the 3rd. An in-band gap restarts that run.
- R8: If no transition arrives for 300 clocks, carrier_det falls.
- R9: rx_data is 1 in every cycle in which carrier_det is 0.
- R10: A change on cmp_in ahead of clock edge c first affects the outputs just after edge c+3. That delay covers two synchronizer flops, one edge/interval register and one decision register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator output from the analog receive path |
| rx_data | output | 1 | Recovered serial data toward the UART, idle high |
| carrier_det | output | 1 | High while a valid in-band carrier is declared |

## Verification
The bench builds the block with its default parameters: a split at 148 clocks, a band from 80 to 240 clocks, an acquire run of 8, a loss run of 4 and a 300-clock silence limit. At these values every boundary can be reached with exact gap lengths: 79/80, 147/148, 240/241 and the 7th/8th and 3rd/4th gaps of a run. A full silence timeout also fits in a few hundred cycles. The 2-cycle synchronizer and the 4-edge decision delay are therefore checked cycle by cycle against a behavioural model.

// File: rtl/fsk_rx_pkg.sv
// Package: shared types for the FSK receive path.
// Assumes: nothing beyond IEEE 1800-2017.
package fsk_rx_pkg;
    // Tone decided from one half period of the comparator signal
    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

    // Counter width that can hold a gap up to lim clocks, plus a saturated value above it
    function automatic int gap_width(input int lim);
        return $clog2(lim + 2);
    endfunction
endpackage

// File: rtl/fsk_rx_sync.sv
// Module: multi-flop synchronizer for an asynchronous single-bit input.
// Assumes: STAGES >= 2; the reset value is 0.
module fsk_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/fsk_rx_interval.sv
// Module: edge detector and gap timer. On each transition of the synchronized
// level it reports the number of clocks since the previous transition. It
// pulses silence_stb once when SILENCE clocks pass with no transition.
// Assumes: the input is already synchronous. The counter starts saturated, so
// the first gap after reset always reads as too long.
module fsk_rx_interval #(
    parameter int CNT_W   = 9,
    parameter int SILENCE = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    output logic             ivl_stb,
    output logic [CNT_W-1:0] ivl_len,
    output logic             silence_stb
);
    localparam logic [CNT_W-1:0] SAT     = '1;
    localparam logic [CNT_W-1:0] SIL_CNT = CNT_W'(SILENCE);

    logic             prev_lvl;
    logic [CNT_W-1:0] cnt;
    logic             edge_w;

    assign edge_w = lvl ^ prev_lvl;

    // Time the gap between transitions and flag silence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl    <= 1'b0;
            cnt         <= SAT;
            ivl_stb     <= 1'b0;
            ivl_len     <= '0;
            silence_stb <= 1'b0;
        end else begin
            prev_lvl    <= lvl;
            ivl_stb     <= edge_w;
            silence_stb <= !edge_w && (cnt == SIL_CNT);
            if (edge_w) begin
                ivl_len <= cnt;
                cnt     <= CNT_W'(1);
            end else if (cnt != SAT) begin
                cnt     <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/fsk_rx_tracker.sv
// Module: tone classifier and carrier qualifier. It judges each reported gap
// as in band or not, counts runs of in-band and out-of-band gaps, and forces
// the data output to the idle mark level while no carrier is declared.
// Assumes: ivl_stb and silence_stb are never high in the same cycle.
module fsk_rx_tracker #(
    parameter int CNT_W   = 9,
    parameter int SPLIT   = 148,
    parameter int MIN_IVL = 80,
    parameter int MAX_IVL = 240,
    parameter int ACQ     = 8,
    parameter int LOSS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_stb,
    input  logic [CNT_W-1:0] ivl_len,
    input  logic             silence_stb,
    output logic             carrier_det,
    output logic             rx_data
);
    import fsk_rx_pkg::*;

    localparam int GW = $clog2(ACQ + 1);
    localparam int BW = $clog2(LOSS + 1);

    logic [GW-1:0] good_q, good_n;
    logic [BW-1:0] bad_q, bad_n;
    logic          cd_q, cd_n;
    tone_e         tone_q, tone_n, tone_w;
    logic          rx_q, rx_n;
    logic          in_band;

    assign in_band = (ivl_len >= CNT_W'(MIN_IVL)) && (ivl_len <= CNT_W'(MAX_IVL));
    assign tone_w  = (ivl_len >= CNT_W'(SPLIT)) ? TONE_MARK : TONE_SPACE;

    // Next-state: run counters, carrier state, held tone and idle-forced data
    always_comb begin
        good_n = good_q;
        bad_n  = bad_q;
        cd_n   = cd_q;
        tone_n = tone_q;
        if (ivl_stb) begin
            if (in_band) begin
                bad_n  = '0;
                tone_n = tone_w;
                if (good_q != GW'(ACQ)) good_n = good_q + GW'(1);
                if (good_n == GW'(ACQ)) cd_n = 1'b1;
            end else begin
                good_n = '0;
                if (bad_q != BW'(LOSS)) bad_n = bad_q + BW'(1);
                if (bad_n == BW'(LOSS)) cd_n = 1'b0;
            end
        end else if (silence_stb) begin
            good_n = '0;
            bad_n  = '0;
            cd_n   = 1'b0;
        end
        rx_n = cd_n ? logic'(tone_n) : 1'b1;
    end

    // Register the qualifier state and the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            bad_q  <= '0;
            cd_q   <= 1'b0;
            tone_q <= TONE_MARK;
            rx_q   <= 1'b1;
        end else begin
            good_q <= good_n;
            bad_q  <= bad_n;
            cd_q   <= cd_n;
            tone_q <= tone_n;
            rx_q   <= rx_n;
        end
    end

    assign carrier_det = cd_q;
    assign rx_data     = rx_q;
endmodule

// File: rtl/fsk_rx_demod.sv
// Module: top of the FSK receive demodulator. Chain: synchronizer, gap timer,
// tone/carrier tracker.
// Assumes: clk is the 460.8 kHz sampling clock and cmp_in is asynchronous to it.
module fsk_rx_demod #(
    parameter int SYNC_STAGES = 2,
    parameter int TONE_SPLIT  = 148,
    parameter int MIN_IVL     = 80,
    parameter int MAX_IVL     = 240,
    parameter int ACQ_RUN     = 8,
    parameter int LOSS_RUN    = 4,
    parameter int SILENCE     = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic rx_data,
    output logic carrier_det
);
    localparam int CNT_W = fsk_rx_pkg::gap_width((SILENCE > MAX_IVL) ? SILENCE : MAX_IVL);

    logic             lvl_s;
    logic             ivl_stb;
    logic [CNT_W-1:0] ivl_len;
    logic             silence_stb;

    fsk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .sync_out (lvl_s)
    );

    fsk_rx_interval #(.CNT_W(CNT_W), .SILENCE(SILENCE)) u_ivl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl         (lvl_s),
        .ivl_stb     (ivl_stb),
        .ivl_len     (ivl_len),
        .silence_stb (silence_stb)
    );

    fsk_rx_tracker #(
        .CNT_W   (CNT_W),
        .SPLIT   (TONE_SPLIT),
        .MIN_IVL (MIN_IVL),
        .MAX_IVL (MAX_IVL),
        .ACQ     (ACQ_RUN),
        .LOSS    (LOSS_RUN)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .ivl_stb     (ivl_stb),
        .ivl_len     (ivl_len),
        .silence_stb (silence_stb),
        .carrier_det (carrier_det),
        .rx_data     (rx_data)
    );
endmodule

// File: rtl/fsk_rx_demod_chk.sv
// Module: assertion checker bound to fsk_rx_demod. It relates the gap-timer
// strobes to the changes seen on the outputs.
// Assumes: the bound instance passes the top's parameters.
module fsk_rx_demod_chk #(
    parameter int CNT_W   = 9,
    parameter int SPLIT   = 148,
    parameter int MIN_IVL = 80,
    parameter int MAX_IVL = 240
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ivl_stb,
    input logic [CNT_W-1:0] ivl_len,
    input logic             silence_stb,
    input logic             carrier_det,
    input logic             rx_data
);
    logic inb;
    assign inb = (ivl_len >= CNT_W'(MIN_IVL)) && (ivl_len <= CNT_W'(MAX_IVL));

    // R9: the data line idles high without a carrier
    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_det |-> rx_data);

    // R5: a carrier is declared only on the back of an in-band gap
    p_acquire_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_det) |-> ($past(ivl_stb) && $past(inb)));

    // R7 and R8: a carrier is dropped only by an out-of-band gap or by silence
    p_loss_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_det) |-> (($past(ivl_stb) && !$past(inb)) || $past(silence_stb)));

    // R8: silence always leaves the carrier down
    p_silence_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        silence_stb |=> !carrier_det);

    // R2, R3, R4: under carrier, the data follows the tone of the last in-band gap
    p_tone_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_stb && inb) |=> (!carrier_det || (rx_data == ($past(ivl_len) >= CNT_W'(SPLIT)))));

    // R10: outputs change only the cycle after a gap or silence strobe
    p_output_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ivl_stb && !silence_stb) |=> ($stable(carrier_det) && $stable(rx_data)));
endmodule

bind fsk_rx_demod fsk_rx_demod_chk #(
    .CNT_W   (CNT_W),
    .SPLIT   (TONE_SPLIT),
    .MIN_IVL (MIN_IVL),
    .MAX_IVL (MAX_IVL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ivl_stb     (ivl_stb),
    .ivl_len     (ivl_len),
    .silence_stb (silence_stb),
    .carrier_det (carrier_det),
    .rx_data     (rx_data)
);

// File: tb/tb_fsk_rx_demod.sv
// Bench: directed gap sequences, plus a behavioural model compared on every clock.
module tb_fsk_rx_demod;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_in = 1'b0;
    logic rx_data, carrier_det;

    int checks = 0;
    int errors = 0;
    int since_tog = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    fsk_rx_demod dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_in      (cmp_in),
        .rx_data     (rx_data),
        .carrier_det (carrier_det)
    );

    always #4 clk = ~clk;

    // Behavioural model: sample history, gap count, pending event, run counters
    bit hist[$];
    int m_cnt, m_len, m_good, m_bad;
    bit m_ev, m_sil, m_cd, m_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_cnt = 1 << 20; m_ev = 0; m_sil = 0;
            m_good = 0; m_bad = 0; m_cd = 0; m_bit = 1;
        end else begin
            if (m_ev) begin
                if (m_len >= 80 && m_len <= 240) begin
                    m_bad = 0; m_bit = (m_len >= 148);
                    m_good++;
                    if (m_good >= 8) m_cd = 1;
                end else begin
                    m_good = 0; m_bad++;
                    if (m_bad >= 4) m_cd = 0;
                end
            end else if (m_sil) begin
                m_good = 0; m_bad = 0; m_cd = 0;
            end
            m_ev  = (hist[1] != hist[0]);
            m_len = m_cnt;
            m_sil = !m_ev && (m_cnt == 300);
            if (m_ev) m_cnt = 1;
            else if (m_cnt < (1 << 20)) m_cnt++;
            hist.push_back(cmp_in);
            void'(hist.pop_front());
        end
    end

    // R10: cycle-exact comparison with the model
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (carrier_det !== m_cd || rx_data !== (m_cd ? m_bit : 1'b1)) begin
                errors++;
                $display("FAIL R10 model: cd=%0b rx=%0b expected cd=%0b rx=%0b",
                         carrier_det, rx_data, m_cd, (m_cd ? m_bit : 1'b1));
            end
        end
    end

    task automatic check(input bit cond, input string tag, input logic act, input logic exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic look(input int n);
        repeat (n) @(negedge clk);
        since_tog += n;
    endtask

    task automatic toggle(input int gap);
        repeat (gap - since_tog) @(negedge clk);
        cmp_in = ~cmp_in;
        since_tog = 0;
    endtask

    task automatic burst(input int gap, input int n);
        for (int i = 0; i < n; i++) toggle(gap);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(carrier_det === 1'b0, "R1 cd in reset", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R1 rx in reset", rx_data, 1'b1);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        look(3);
        check(carrier_det === 1'b0, "R1 cd after reset", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R1 rx after reset", rx_data, 1'b1);

        // First edge is out of band; then 7 in-band gaps
        burst(192, 8);
        look(5);
        check(carrier_det === 1'b0, "R5 no carrier after 7", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R9 idle without carrier", rx_data, 1'b1);
        // 8th in-band gap; watch the exact edge of R10
        toggle(192);
        look(3);
        check(carrier_det === 1'b0, "R10 not before c+3", carrier_det, 1'b0);
        look(1);
        check(carrier_det === 1'b1, "R5 carrier on 8th", carrier_det, 1'b1);
        check(rx_data === 1'b1, "R2 mark tone", rx_data, 1'b1);

        burst(105, 4); look(5);
        check(rx_data === 1'b0, "R3 space tone", rx_data, 1'b0);
        burst(192, 2); look(5);
        check(rx_data === 1'b1, "R2 mark again", rx_data, 1'b1);

        toggle(147); look(5);
        check(rx_data === 1'b0, "R4 147 is space", rx_data, 1'b0);
        toggle(148); look(5);
        check(rx_data === 1'b1, "R4 148 is mark", rx_data, 1'b1);
        toggle(80); look(5);
        check(carrier_det === 1'b1, "R6 80 in band", carrier_det, 1'b1);
        check(rx_data === 1'b0, "R4 80 is space", rx_data, 1'b0);
        toggle(240); look(5);
        check(carrier_det === 1'b1, "R6 240 in band", carrier_det, 1'b1);
        check(rx_data === 1'b1, "R4 240 is mark", rx_data, 1'b1);

        // Loss run: 3 bad, then a good gap resets the run, then 4 bad
        burst(60, 3); look(5);
        check(carrier_det === 1'b1, "R7 held after 3 bad", carrier_det, 1'b1);
        toggle(192); burst(60, 3); look(5);
        check(carrier_det === 1'b1, "R7 run restarted", carrier_det, 1'b1);
        toggle(60); look(5);
        check(carrier_det === 1'b0, "R7 dropped on 4th bad", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R9 idle after loss", rx_data, 1'b1);

        // Acquisition restarts on 79 and 241
        burst(105, 7); toggle(79); look(5);
        check(carrier_det === 1'b0, "R6 79 breaks run", carrier_det, 1'b0);
        burst(105, 7); toggle(241); look(5);
        check(carrier_det === 1'b0, "R6 241 breaks run", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R9 idle while acquiring", rx_data, 1'b1);
        burst(105, 8); look(5);
        check(carrier_det === 1'b1, "R5 reacquired", carrier_det, 1'b1);
        check(rx_data === 1'b0, "R3 space after reacquire", rx_data, 1'b0);

        // Silence timeout
        look(290);
        check(carrier_det === 1'b1, "R8 held before timeout", carrier_det, 1'b1);
        look(15);
        check(carrier_det === 1'b0, "R8 dropped on silence", carrier_det, 1'b0);
        check(rx_data === 1'b1, "R9 idle after silence", rx_data, 1'b1);

        // First edge after silence is out of band: 8 edges give only 7 in-band gaps
        burst(192, 8); look(5);
        check(carrier_det === 1'b0, "R6 first edge after silence", carrier_det, 1'b0);

        // Reset in mid-stream
        burst(192, 2);
        @(negedge clk); rst_n = 1'b0; cmp_en = 1'b0;
        @(negedge clk);
        check(carrier_det === 1'b0 && rx_data === 1'b1, "R1 reset mid-stream", carrier_det, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule